// File: doc/BRIEF.md
# SPI Data Output Enable Sequencer

This block drives the active-low enable of the tri-state buffer on a serial port's data output. It watches the serial clock and the select line of the port. It counts bit edges and opens or closes the enable so that the output buffer turns on before the first valid bit and turns off after the last one. Three frame formats are handled: Motorola SPI, TI synchronous serial and Microwire. In each format the block can act as master or as slave.

The serial clock and the select line arrive asynchronously. Each passes through a synchroniser, and an edge detector then produces one-cycle rise and fall strobes in the system clock domain. Every change of the enable happens on one of these strobes. The frame length is configurable from 4 to 16 bits. A "next frame pending" input lets TI frames run back to back without closing the enable between them. The block does not shift data, generate the serial clock or buffer data.

Top module: `spi_oe_seq`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset, `oe_n_o` is high (disabled).
- R2: When format code 0 (Motorola) or code 3 (treated as Motorola) is selected, in either role, `oe_n_o` copies the synchronised level of `ss_n_i`.
- R3: Format code 1 (TI) with master role. The enable goes low on a serial clock falling edge that sees `ss_n_i` low. It goes high again on the (L+1)th falling edge after that one, where L is the effective frame length.
- R4: Format code 1 (TI) with slave role. After a falling edge that sees `ss_n_i` low, the enable goes low on the next rising edge, which drives the MSB. It goes high on the (L+1)th rising edge, counting that MSB edge as the first.
- R5: In TI format, if `next_pend_i` is high at the edge that would close the enable, the enable stays low. That edge then becomes the start edge of the next frame, and the closing count restarts from it.
- R6: Format code 2 (Microwire) with master role. The enable goes low when `ss_n_i` goes low. It goes high on the 8th serial clock falling edge, which starts the turnaround bit, and stays high until `ss_n_i` returns high.
- R7: Format code 2 (Microwire) with slave role. The enable goes low on the 9th falling edge after `ss_n_i` goes low, which starts the first response bit. It goes high on the (9+L)th falling edge.
- R8: In Microwire format, a high level on `ss_n_i` closes the enable at once, whatever the bit count, and returns the block to idle.
- R9: A `frame_len_i` value below 4 acts as 4, and a value above 16 acts as 16.
- R10: Every change of `oe_n_o` follows a pin change by exactly 3 system clock cycles: two synchroniser stages plus one output register. There is no change without a serial clock or select edge, or a change of format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fmt_i | input | 2 | Frame format: 0 Motorola, 1 TI, 2 Microwire, 3 as Motorola |
| master_i | input | 1 | 1 selects the master role, 0 the slave role |
| frame_len_i | input | 5 | Data bits per frame, clamped to 4..16 |
| sclk_i | input | 1 | Serial clock (asynchronous) |
| ss_n_i | input | 1 | Select line, active low (frame sync pulse in TI format) |
| next_pend_i | input | 1 | Another frame follows at once (TI back-to-back) |
| oe_n_o | output | 1 | Data output enable, active low |

## Verification
The edge counter decides when the enable opens and closes. A wrong count therefore shows at the port as an enable that closes one or more serial bits early or late. It becomes visible at the LSB boundary of the same frame, or at bit 9 of a Microwire frame. If the sequencer gets stuck in the wrong state, the enable either never opens, or stays open after the select line rises or after the closing edge. This shows up within one frame. If an extra synchroniser stage is added or one is dropped, every transition moves by a system clock cycle. Checking the enable exactly three cycles after a select edge catches this.

// File: rtl/spi_oe_pkg.sv
package spi_oe_pkg;

    typedef enum logic [1:0] {
        FMT_MOTO  = 2'd0,
        FMT_TI    = 2'd1,
        FMT_MWIRE = 2'd2,
        FMT_RSVD  = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_ON   = 2'd2,
        ST_OFF  = 2'd3
    } seq_st_e;

endpackage

// File: rtl/spi_oe_sync.sv
module spi_oe_sync #(
    parameter int          W      = 2,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] lvl,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);

    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d.pipe[0] = din;
        for (int k = 1; k < STAGES; k++) begin
            sync_d.pipe[k] = sync_q.pipe[k-1];
        end
        sync_d.prev = sync_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q.pipe <= {STAGES{RST_VAL}};
            sync_q.prev <= RST_VAL;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl  = sync_q.pipe[STAGES-1];
    assign rise = lvl & ~sync_q.prev;
    assign fall = ~lvl & sync_q.prev;

endmodule

// File: rtl/spi_oe_limits.sv
module spi_oe_limits #(
    parameter int LEN_W    = 5,
    parameter int CNT_W    = 5,
    parameter int MIN_LEN  = 4,
    parameter int MAX_LEN  = 16,
    parameter int CMD_BITS = 8
) (
    input  logic [LEN_W-1:0] frame_len_i,
    output logic [CNT_W-1:0] ti_last_o,
    output logic [CNT_W-1:0] mw_turn_o,
    output logic [CNT_W-1:0] mw_resp_o,
    output logic [CNT_W-1:0] mw_last_o
);

    logic [CNT_W-1:0] len_c;

    always_comb begin
        if (frame_len_i < LEN_W'(MIN_LEN)) begin
            len_c = CNT_W'(MIN_LEN);
        end else if (frame_len_i > LEN_W'(MAX_LEN)) begin
            len_c = CNT_W'(MAX_LEN);
        end else begin
            len_c = CNT_W'(frame_len_i);
        end
        ti_last_o = len_c + CNT_W'(1);
        mw_turn_o = CNT_W'(CMD_BITS);
        mw_resp_o = CNT_W'(CMD_BITS + 1);
        mw_last_o = CNT_W'(CMD_BITS + 1) + len_c;
    end

    always_comb begin
        assert (len_c >= CNT_W'(MIN_LEN) && len_c <= CNT_W'(MAX_LEN))
            else $error("assert_len_clamp_R9");
    end

endmodule

// File: rtl/spi_oe_seq.sv
module spi_oe_seq
    import spi_oe_pkg::*;
#(
    parameter int MIN_LEN     = 4,
    parameter int MAX_LEN     = 16,
    parameter int CMD_BITS    = 8,
    parameter int SYNC_STAGES = 2,
    parameter int LEN_W       = $clog2(MAX_LEN + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       fmt_i,
    input  logic             master_i,
    input  logic [LEN_W-1:0] frame_len_i,
    input  logic             sclk_i,
    input  logic             ss_n_i,
    input  logic             next_pend_i,
    output logic             oe_n_o
);

    localparam int CNT_W = $clog2(CMD_BITS + MAX_LEN + 2);

    typedef struct packed {
        seq_st_e          st;
        logic [CNT_W-1:0] cnt;
        logic             oe_n;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [1:0]       pin_lvl, pin_rise, pin_fall;
    logic             sclk_rise, sclk_fall, ss_lvl, any_edge;
    logic [CNT_W-1:0] ti_last, mw_turn, mw_resp, mw_last, cnt_inc;
    logic             ti_edge;
    fmt_e             fmt;

    spi_oe_sync #(
        .W       (2),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (2'b10)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ss_n_i, sclk_i}),
        .lvl   (pin_lvl),
        .rise  (pin_rise),
        .fall  (pin_fall)
    );

    spi_oe_limits #(
        .LEN_W    (LEN_W),
        .CNT_W    (CNT_W),
        .MIN_LEN  (MIN_LEN),
        .MAX_LEN  (MAX_LEN),
        .CMD_BITS (CMD_BITS)
    ) u_limits (
        .frame_len_i (frame_len_i),
        .ti_last_o   (ti_last),
        .mw_turn_o   (mw_turn),
        .mw_resp_o   (mw_resp),
        .mw_last_o   (mw_last)
    );

    assign sclk_rise = pin_rise[0];
    assign sclk_fall = pin_fall[0];
    assign ss_lvl    = pin_lvl[1];
    assign any_edge  = (|pin_rise) | (|pin_fall);
    assign fmt       = fmt_e'(fmt_i);
    assign cnt_inc   = seq_q.cnt + CNT_W'(1);
    // TI master counts sampling (falling) edges, TI slave counts launch (rising) edges
    assign ti_edge   = master_i ? sclk_fall : sclk_rise;

    always_comb begin
        seq_d = seq_q;
        unique case (fmt)
            FMT_TI: begin
                unique case (seq_q.st)
                    ST_IDLE: begin
                        if (sclk_fall && !ss_lvl) begin
                            seq_d.cnt = '0;
                            if (master_i) begin
                                seq_d.st   = ST_ON;
                                seq_d.oe_n = 1'b0;
                            end else begin
                                seq_d.st = ST_ARM;
                            end
                        end
                    end
                    ST_ARM: begin
                        if (sclk_rise) begin
                            seq_d.st   = ST_ON;
                            seq_d.cnt  = CNT_W'(1);
                            seq_d.oe_n = 1'b0;
                        end
                    end
                    ST_ON: begin
                        if (ti_edge) begin
                            if (cnt_inc == ti_last) begin
                                if (next_pend_i) begin
                                    seq_d.cnt = master_i ? '0 : CNT_W'(1);
                                end else begin
                                    seq_d.st   = ST_IDLE;
                                    seq_d.cnt  = '0;
                                    seq_d.oe_n = 1'b1;
                                end
                            end else begin
                                seq_d.cnt = cnt_inc;
                            end
                        end
                    end
                    default: begin
                        seq_d.st   = ST_IDLE;
                        seq_d.cnt  = '0;
                        seq_d.oe_n = 1'b1;
                    end
                endcase
            end
            FMT_MWIRE: begin
                if (ss_lvl) begin
                    seq_d.st   = ST_IDLE;
                    seq_d.cnt  = '0;
                    seq_d.oe_n = 1'b1;
                end else begin
                    unique case (seq_q.st)
                        ST_IDLE: begin
                            seq_d.cnt  = '0;
                            seq_d.st   = master_i ? ST_ON : ST_ARM;
                            seq_d.oe_n = !master_i;
                        end
                        ST_ARM: begin
                            if (sclk_fall) begin
                                seq_d.cnt = cnt_inc;
                                if (cnt_inc == mw_resp) begin
                                    seq_d.st   = ST_ON;
                                    seq_d.oe_n = 1'b0;
                                end
                            end
                        end
                        ST_ON: begin
                            if (sclk_fall) begin
                                seq_d.cnt = cnt_inc;
                                if (cnt_inc == (master_i ? mw_turn : mw_last)) begin
                                    seq_d.st   = ST_OFF;
                                    seq_d.oe_n = 1'b1;
                                end
                            end
                        end
                        default: begin
                            seq_d.oe_n = 1'b1;
                        end
                    endcase
                end
            end
            default: begin
                seq_d.st   = ST_IDLE;
                seq_d.cnt  = '0;
                seq_d.oe_n = ss_lvl;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q.st   <= ST_IDLE;
            seq_q.cnt  <= '0;
            seq_q.oe_n <= 1'b1;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign oe_n_o = seq_q.oe_n;

    assert_moto_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == FMT_MOTO || fmt_i == FMT_RSVD) |=> (oe_n_o == $past(ss_lvl)));

    assert_mw_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fmt_i == FMT_MWIRE && ss_lvl) |=> oe_n_o);

    assert_cnt_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        seq_q.cnt <= mw_last);

    assert_oe_on_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_n_o != $past(oe_n_o)) |-> ($past(any_edge) || ($past(fmt_i) != $past(fmt_i, 2))));

endmodule

// File: tb/spi_oe_seq_tb.sv
module spi_oe_seq_tb;

    typedef struct packed {
        logic [1:0] fmt;
        logic       mst;
        logic [4:0] len;
        logic [7:0] pend_until;
        logic [7:0] ss_hi;
        logic [7:0] on_step;
        logic [7:0] off_step;
        logic [7:0] last_step;
    } vec_t;

    // fmt, master, len, pend_until, ss_hi, on, off, last
    localparam vec_t VECS [16] = '{
        '{2'd0, 1'b1, 5'd8,  8'd0,  8'd19, 8'd1,  8'd19, 8'd20},  // R2 master
        '{2'd0, 1'b0, 5'd8,  8'd0,  8'd19, 8'd1,  8'd19, 8'd20},  // R2 slave
        '{2'd1, 1'b1, 5'd8,  8'd0,  8'd0,  8'd2,  8'd20, 8'd24},  // R3
        '{2'd1, 1'b0, 5'd8,  8'd0,  8'd0,  8'd3,  8'd19, 8'd24},  // R4
        '{2'd1, 1'b1, 5'd4,  8'd0,  8'd0,  8'd2,  8'd12, 8'd16},  // R3 short
        '{2'd1, 1'b0, 5'd16, 8'd0,  8'd0,  8'd3,  8'd35, 8'd40},  // R4 long
        '{2'd2, 1'b1, 5'd8,  8'd0,  8'd39, 8'd1,  8'd17, 8'd40},  // R6
        '{2'd2, 1'b0, 5'd8,  8'd0,  8'd39, 8'd19, 8'd35, 8'd40},  // R7
        '{2'd2, 1'b0, 5'd4,  8'd0,  8'd31, 8'd19, 8'd27, 8'd32},  // R7 short
        '{2'd2, 1'b0, 5'd16, 8'd0,  8'd55, 8'd19, 8'd51, 8'd56},  // R7 long
        '{2'd1, 1'b1, 5'd2,  8'd0,  8'd0,  8'd2,  8'd12, 8'd16},  // R9 low clamp
        '{2'd1, 1'b0, 5'd20, 8'd0,  8'd0,  8'd3,  8'd35, 8'd40},  // R9 high clamp
        '{2'd1, 1'b1, 5'd4,  8'd13, 8'd0,  8'd2,  8'd22, 8'd26},  // R5 master
        '{2'd1, 1'b0, 5'd4,  8'd12, 8'd0,  8'd3,  8'd19, 8'd24},  // R5 slave
        '{2'd2, 1'b0, 5'd16, 8'd0,  8'd25, 8'd19, 8'd25, 8'd28},  // R8 abort
        '{2'd3, 1'b1, 5'd8,  8'd0,  8'd19, 8'd1,  8'd19, 8'd20}   // R2 code 3
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] fmt_i = 2'd0;
    logic       master_i = 1'b0;
    logic [4:0] frame_len_i = 5'd8;
    logic       sclk_i = 1'b0;
    logic       ss_n_i = 1'b1;
    logic       next_pend_i = 1'b0;
    logic       oe_n_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #4 clk = ~clk;

    spi_oe_seq u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .fmt_i       (fmt_i),
        .master_i    (master_i),
        .frame_len_i (frame_len_i),
        .sclk_i      (sclk_i),
        .ss_n_i      (ss_n_i),
        .next_pend_i (next_pend_i),
        .oe_n_o      (oe_n_o)
    );

    task automatic check(input string req, input logic act, input logic exp, input int tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s (case %0d): oe_n_o actual %b expected %b", req, tag, act, exp);
        end
    endtask

    function automatic string req_of(input vec_t v);
        if (v.pend_until != 0) return "R5";
        if (v.len < 4 || v.len > 16) return "R9";
        if (v.fmt == 2'd2 && v.ss_hi < v.off_step + 2 && !v.mst) return "R8";
        case (v.fmt)
            2'd1: return v.mst ? "R3" : "R4";
            2'd2: return v.mst ? "R6" : "R7";
            default: return "R2";
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        check("R1", oe_n_o, 1'b1, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", oe_n_o, 1'b1, 0);

        // R10: select edge reaches oe_n_o exactly three clocks later
        fmt_i  = 2'd0;
        ss_n_i = 1'b0;
        repeat (2) @(negedge clk);
        check("R10", oe_n_o, 1'b1, 1);
        @(negedge clk);
        check("R10", oe_n_o, 1'b0, 2);
        ss_n_i = 1'b1;
        repeat (2) @(negedge clk);
        check("R10", oe_n_o, 1'b0, 3);
        @(negedge clk);
        check("R10", oe_n_o, 1'b1, 4);
        repeat (4) @(negedge clk);

        for (int v = 0; v < 16; v++) begin
            vec_t cv;
            cv = VECS[v];
            fmt_i       = cv.fmt;
            master_i    = cv.mst;
            frame_len_i = cv.len;
            for (int i = 0; i <= int'(cv.last_step); i++) begin
                next_pend_i = (i < int'(cv.pend_until));
                if (i == 0) begin
                    sclk_i = 1'b0;
                    ss_n_i = 1'b1;
                end else if (cv.fmt == 2'd1) begin
                    sclk_i = i[0];
                    ss_n_i = !(i < 3);
                end else begin
                    ss_n_i = !(i < int'(cv.ss_hi));
                    if (i >= 2 && i < int'(cv.ss_hi)) sclk_i = ~sclk_i;
                end
                repeat (8) @(negedge clk);
                check(req_of(cv), oe_n_o,
                      !(i >= int'(cv.on_step) && i < int'(cv.off_step)), v * 100 + i);
            end
            next_pend_i = 1'b0;
            repeat (8) @(negedge clk);
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #1600000;
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule